// File: doc/BRIEF.md
# Pipelined Split-Transaction Bus Tracker

This block sits between a processor core and a system bus whose address and data phases are separate tenures with independent arbitration. The core hands it one transaction at a time: a load, a store or a snoop copyback, each with an address, a tag and transfer attributes (size, burst, write-through, caching-inhibited). The block requests the address bus, announces the transaction with a one-cycle start pulse, holds the address and attributes until the bus terminates the address phase, and goes back to arbitration if the termination asks for a retry.

Transactions whose address phase has been acknowledged wait in an in-order queue for the data bus. The oldest one requests the data bus and, once granted, counts data-termination beats: one for a single-beat transfer, four for a burst. When its last beat is terminated it leaves the queue and its tag is reported to the core. A new address tenure may run while older transactions are still waiting for, or moving, data.

Outstanding transactions are counted from acceptance to final data beat. A request is held back whenever the overall cap or the cap of its own type is reached. Requests of other types stay eligible while their own caps allow it.

Top module: `bus_trk_top`

## Requirements
- R1: While reset is held and in the first cycle after it, abus_req, addr_start, dbus_req and done_valid are low and req_ready is high for a load request.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. From the next cycle abus_req is high, and it stays high until an edge where abus_gnt is sampled high.
- R3: addr_start is high for exactly the one cycle after the grant edge. From that cycle until the address phase ends, a_addr, a_kind, a_size, a_burst, a_wt and a_ci carry the accepted values. Outside the address phase they are zero.
- R4: If aterm_retry is sampled high during the address phase, which includes the start cycle, the phase ends, abus_req rises again in the next cycle, and the same address and attributes are issued again. Retry takes precedence over aterm_ack.
- R5: If aterm_ack is sampled high without retry during the address phase, the transaction joins the data queue. From the next cycle the block can accept a new request even though older data tenures are pending.
- R6: dbus_req is high in every cycle in which the queue holds a transaction and no data tenure is running. A data tenure starts on an edge where dbus_req and dbus_gnt are both high.
- R7: A data tenure ends on its first sampled dterm when a_burst was 0, and on its fourth sampled dterm when a_burst was 1.
- R8: done_valid is high for one cycle, the cycle after the edge that ends a data tenure, and done_tag then shows that transaction's tag. Completions follow address acknowledgement order.
- R9: At most 5 transactions are outstanding, counted from acceptance to the end of the data tenure. With 5 outstanding, req_ready is low for every type.
- R10: req_kind encodes 0 as load, 1 as store, 2 as snoop copyback and 3 as never accepted. At most 4 loads, 4 stores and 1 copyback are outstanding. A type at its cap sees req_ready low while the other types stay ready if their own caps and the total allow it.
- R11: dterm outside a data tenure, and aterm_ack or aterm_retry outside an address phase, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core offers a transaction |
| req_ready | output | 1 | Transaction will be taken at this edge |
| req_kind | input | 2 | 0 load, 1 store, 2 snoop copyback |
| req_addr | input | AW | Transaction address |
| req_tag | input | TW | Core tag returned on completion |
| req_burst | input | 1 | 1 for a four-beat burst |
| req_size | input | SZW | Transfer size code |
| req_wt | input | 1 | Write-through flag |
| req_ci | input | 1 | Caching-inhibited flag |
| abus_req | output | 1 | Address bus request |
| abus_gnt | input | 1 | Address bus grant |
| addr_start | output | 1 | One-cycle address start pulse |
| a_addr | output | AW | Address during the address phase |
| a_kind | output | 2 | Transaction type during the address phase |
| a_size | output | SZW | Size during the address phase |
| a_burst | output | 1 | Burst flag during the address phase |
| a_wt | output | 1 | Write-through flag during the address phase |
| a_ci | output | 1 | Caching-inhibited flag during the address phase |
| aterm_ack | input | 1 | Address phase acknowledged |
| aterm_retry | input | 1 | Address phase must be repeated |
| dbus_req | output | 1 | Data bus request |
| dbus_gnt | input | 1 | Data bus grant |
| dterm | input | 1 | Data beat terminated |
| done_valid | output | 1 | One transaction completed |
| done_tag | output | TW | Tag of the completed transaction |

## Verification
Randomly timed grants and terminations are applied with and without traffic. When driven with no traffic, they show whether stray terminations are ignored. A retry-heavy mix sorts correct reissue from silent acknowledgement or a lost address. Holding off the data grant while loads, a store and a copyback are offered in turn isolates each type cap from the overall cap. It also shows that the address side keeps running while data is blocked. A long mixed stream of single-beat and burst transactions checks beat counts and in-order tags against the reference model in every cycle.

// File: rtl/bus_trk_pkg.sv
// Shared encodings for the bus transaction tracker.
package bus_trk_pkg;
    localparam int NKIND = 3;

    typedef enum logic [1:0] {
        K_LOAD      = 2'd0,
        K_STORE     = 2'd1,
        K_COPYBACK  = 2'd2
    } kind_e;

    typedef enum logic [1:0] {
        AS_IDLE,
        AS_ARB,
        AS_START,
        AS_WAIT
    } aseq_e;
endpackage

// File: rtl/bt_caps.sv
// Outstanding-transaction accounting.
// Keeps one overall counter and one counter per transaction type.
// Grants eligibility per type.
// Assumes inc and dec can coincide and never exceed the caps (inc only when allowed).
module bt_caps
    import bus_trk_pkg::*;
#(
    parameter int MAX_TOTAL = 5,
    parameter int MAX_LOAD  = 4,
    parameter int MAX_STORE = 4,
    parameter int MAX_CB    = 1,
    parameter int CW        = $clog2(MAX_TOTAL + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       inc,
    input  logic [1:0]                 inc_kind,
    input  logic                       dec,
    input  logic [1:0]                 dec_kind,
    output logic [NKIND-1:0]           allow,
    output logic [CW-1:0]              tot_cnt,
    output logic [NKIND-1:0][CW-1:0]   kind_cnt
);
    logic [CW-1:0] tot_q;
    logic          room_total;

    // Overall outstanding count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tot_q <= '0;
        else if (inc && !dec)
            tot_q <= tot_q + CW'(1);
        else if (dec && !inc)
            tot_q <= tot_q - CW'(1);
    end

    assign room_total = (tot_q < CW'(MAX_TOTAL));
    assign tot_cnt    = tot_q;

    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        localparam int LIM = (k == int'(K_LOAD))  ? MAX_LOAD :
                             (k == int'(K_STORE)) ? MAX_STORE : MAX_CB;
        logic [CW-1:0] cnt_q;
        logic          inc_k;
        logic          dec_k;

        assign inc_k = inc && (inc_kind == 2'(k));
        assign dec_k = dec && (dec_kind == 2'(k));

        // Per-type outstanding count.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (inc_k && !dec_k)
                cnt_q <= cnt_q + CW'(1);
            else if (dec_k && !inc_k)
                cnt_q <= cnt_q - CW'(1);
        end

        assign allow[k]    = room_total && (cnt_q < CW'(LIM));
        assign kind_cnt[k] = cnt_q;
    end
endmodule

// File: rtl/bt_addr_seq.sv
// Address tenure sequencer.
// Holds one accepted transaction, arbitrates for the address bus and pulses
// the start on the first owned cycle. It presents address and attributes
// until termination and goes back to arbitration on retry.
// Assumes the external arbiter keeps the grant meaningful only while requested.
module bt_addr_seq
    import bus_trk_pkg::*;
#(
    parameter int AW  = 32,
    parameter int TW  = 4,
    parameter int SZW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [1:0]      in_kind,
    input  logic [AW-1:0]   in_addr,
    input  logic [TW-1:0]   in_tag,
    input  logic            in_burst,
    input  logic [SZW-1:0]  in_size,
    input  logic            in_wt,
    input  logic            in_ci,
    output logic            idle,
    output logic            abus_req,
    input  logic            abus_gnt,
    output logic            addr_start,
    input  logic            aterm_ack,
    input  logic            aterm_retry,
    output logic [AW-1:0]   a_addr,
    output logic [1:0]      a_kind,
    output logic [SZW-1:0]  a_size,
    output logic            a_burst,
    output logic            a_wt,
    output logic            a_ci,
    output logic            tenure,
    output logic [AW-1:0]   hold_addr,
    output logic            push,
    output logic [TW-1:0]   push_tag,
    output logic [1:0]      push_kind,
    output logic            push_burst
);
    aseq_e          st_q;
    logic [AW-1:0]  addr_q;
    logic [TW-1:0]  tag_q;
    logic [1:0]     kind_q;
    logic           burst_q;
    logic [SZW-1:0] size_q;
    logic           wt_q;
    logic           ci_q;

    // Address tenure state walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= AS_IDLE;
        end else begin
            unique case (st_q)
                AS_IDLE:  if (take) st_q <= AS_ARB;
                AS_ARB:   if (abus_gnt) st_q <= AS_START;
                default: begin
                    if (aterm_retry)    st_q <= AS_ARB;
                    else if (aterm_ack) st_q <= AS_IDLE;
                    else                st_q <= AS_WAIT;
                end
            endcase
        end
    end

    // Capture the transaction when it is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            tag_q   <= '0;
            kind_q  <= '0;
            burst_q <= 1'b0;
            size_q  <= '0;
            wt_q    <= 1'b0;
            ci_q    <= 1'b0;
        end else if (take && (st_q == AS_IDLE)) begin
            addr_q  <= in_addr;
            tag_q   <= in_tag;
            kind_q  <= in_kind;
            burst_q <= in_burst;
            size_q  <= in_size;
            wt_q    <= in_wt;
            ci_q    <= in_ci;
        end
    end

    // Bus-facing decode of the state.
    always_comb begin
        idle       = (st_q == AS_IDLE);
        abus_req   = (st_q == AS_ARB);
        addr_start = (st_q == AS_START);
        tenure     = (st_q == AS_START) || (st_q == AS_WAIT);
        a_addr     = tenure ? addr_q  : '0;
        a_kind     = tenure ? kind_q  : '0;
        a_size     = tenure ? size_q  : '0;
        a_burst    = tenure && burst_q;
        a_wt       = tenure && wt_q;
        a_ci       = tenure && ci_q;
        push       = tenure && aterm_ack && !aterm_retry;
    end

    assign hold_addr  = addr_q;
    assign push_tag   = tag_q;
    assign push_kind  = kind_q;
    assign push_burst = burst_q;
endmodule

// File: rtl/bt_data_seq.sv
// Data tenure sequencer.
// Keeps address-acknowledged transactions in order, requests the data bus
// for the oldest, counts termination beats and reports completion by tag.
// Assumes the caller never pushes into a full queue.
module bt_data_seq #(
    parameter int TW    = 4,
    parameter int DEPTH = 5,
    parameter int BEATS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [TW-1:0]   push_tag,
    input  logic [1:0]      push_kind,
    input  logic            push_burst,
    output logic            dbus_req,
    input  logic            dbus_gnt,
    input  logic            dterm,
    output logic            xfer,
    output logic            fin,
    output logic [1:0]      fin_kind,
    output logic            done_valid,
    output logic [TW-1:0]   done_tag
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int BW   = (BEATS > 1) ? $clog2(BEATS) : 1;

    logic [TW-1:0]  tag_mem   [DEPTH];
    logic [1:0]     kind_mem  [DEPTH];
    logic           burst_mem [DEPTH];
    logic [PW-1:0]  wr_ptr;
    logic [PW-1:0]  rd_ptr;
    logic [CNTW-1:0] cnt_q;
    logic           xfer_q;
    logic [BW-1:0]  beat_q;
    logic [BW-1:0]  last_beat;
    logic           done_q;
    logic [TW-1:0]  done_tag_q;

    // Queue storage write.
    always_ff @(posedge clk) begin
        if (push) begin
            tag_mem[wr_ptr]   <= push_tag;
            kind_mem[wr_ptr]  <= push_kind;
            burst_mem[wr_ptr] <= push_burst;
        end
    end

    // Queue pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            if (fin)
                rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            if (push && !fin)
                cnt_q <= cnt_q + CNTW'(1);
            else if (fin && !push)
                cnt_q <= cnt_q - CNTW'(1);
        end
    end

    assign last_beat = burst_mem[rd_ptr] ? BW'(BEATS - 1) : '0;
    assign dbus_req  = !xfer_q && (cnt_q != '0);
    assign fin       = xfer_q && dterm && (beat_q == last_beat);
    assign fin_kind  = kind_mem[rd_ptr];
    assign xfer      = xfer_q;

    // Data tenure ownership and beat counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_q <= 1'b0;
            beat_q <= '0;
        end else if (dbus_req && dbus_gnt) begin
            xfer_q <= 1'b1;
            beat_q <= '0;
        end else if (fin) begin
            xfer_q <= 1'b0;
        end else if (xfer_q && dterm) begin
            beat_q <= beat_q + BW'(1);
        end
    end

    // Registered completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            done_tag_q <= '0;
        end else begin
            done_q <= fin;
            if (fin)
                done_tag_q <= tag_mem[rd_ptr];
        end
    end

    assign done_valid = done_q;
    assign done_tag   = done_tag_q;
endmodule

// File: rtl/bus_trk_top.sv
// Pipelined split-transaction bus tracker, top level.
// Accepts one core request at a time when the address side is free and the caps
// allow it. It then runs the address tenure and hands acknowledged transactions
// to the in-order data sequencer.
// Assumes external arbiters and terminators follow the request/grant ports.
module bus_trk_top
    import bus_trk_pkg::*;
#(
    parameter int AW        = 32,
    parameter int TW        = 4,
    parameter int SZW       = 3,
    parameter int MAX_TOTAL = 5,
    parameter int MAX_LOAD  = 4,
    parameter int MAX_STORE = 4,
    parameter int MAX_CB    = 1,
    parameter int BEATS     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [1:0]      req_kind,
    input  logic [AW-1:0]   req_addr,
    input  logic [TW-1:0]   req_tag,
    input  logic            req_burst,
    input  logic [SZW-1:0]  req_size,
    input  logic            req_wt,
    input  logic            req_ci,
    output logic            abus_req,
    input  logic            abus_gnt,
    output logic            addr_start,
    output logic [AW-1:0]   a_addr,
    output logic [1:0]      a_kind,
    output logic [SZW-1:0]  a_size,
    output logic            a_burst,
    output logic            a_wt,
    output logic            a_ci,
    input  logic            aterm_ack,
    input  logic            aterm_retry,
    output logic            dbus_req,
    input  logic            dbus_gnt,
    input  logic            dterm,
    output logic            done_valid,
    output logic [TW-1:0]   done_tag
);
    localparam int CW = $clog2(MAX_TOTAL + 1);

    logic [NKIND-1:0]         allow;
    logic [3:0]               allow_pad;
    logic [CW-1:0]            tot_cnt;
    logic [NKIND-1:0][CW-1:0] kind_cnt;
    logic                     a_idle;
    logic                     a_tenure;
    logic [AW-1:0]            hold_addr;
    logic                     take;
    logic                     push;
    logic [TW-1:0]            push_tag;
    logic [1:0]               push_kind;
    logic                     push_burst;
    logic                     d_xfer;
    logic                     fin;
    logic [1:0]               fin_kind;

    assign allow_pad = {{(4 - NKIND){1'b0}}, allow};
    assign req_ready = a_idle && allow_pad[req_kind];
    assign take      = req_valid && req_ready;

    bt_caps #(
        .MAX_TOTAL (MAX_TOTAL),
        .MAX_LOAD  (MAX_LOAD),
        .MAX_STORE (MAX_STORE),
        .MAX_CB    (MAX_CB),
        .CW        (CW)
    ) u_caps (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (take),
        .inc_kind (req_kind),
        .dec      (fin),
        .dec_kind (fin_kind),
        .allow    (allow),
        .tot_cnt  (tot_cnt),
        .kind_cnt (kind_cnt)
    );

    bt_addr_seq #(
        .AW  (AW),
        .TW  (TW),
        .SZW (SZW)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .in_kind     (req_kind),
        .in_addr     (req_addr),
        .in_tag      (req_tag),
        .in_burst    (req_burst),
        .in_size     (req_size),
        .in_wt       (req_wt),
        .in_ci       (req_ci),
        .idle        (a_idle),
        .abus_req    (abus_req),
        .abus_gnt    (abus_gnt),
        .addr_start  (addr_start),
        .aterm_ack   (aterm_ack),
        .aterm_retry (aterm_retry),
        .a_addr      (a_addr),
        .a_kind      (a_kind),
        .a_size      (a_size),
        .a_burst     (a_burst),
        .a_wt        (a_wt),
        .a_ci        (a_ci),
        .tenure      (a_tenure),
        .hold_addr   (hold_addr),
        .push        (push),
        .push_tag    (push_tag),
        .push_kind   (push_kind),
        .push_burst  (push_burst)
    );

    bt_data_seq #(
        .TW    (TW),
        .DEPTH (MAX_TOTAL),
        .BEATS (BEATS)
    ) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_tag   (push_tag),
        .push_kind  (push_kind),
        .push_burst (push_burst),
        .dbus_req   (dbus_req),
        .dbus_gnt   (dbus_gnt),
        .dterm      (dterm),
        .xfer       (d_xfer),
        .fin        (fin),
        .fin_kind   (fin_kind),
        .done_valid (done_valid),
        .done_tag   (done_tag)
    );
endmodule

// File: rtl/bus_trk_checker.sv
// Protocol and cap assertions for bus_trk_top, attached with bind.
module bus_trk_checker #(
    parameter int AW        = 32,
    parameter int CW        = 3,
    parameter int MAX_TOTAL = 5,
    parameter int MAX_LOAD  = 4,
    parameter int MAX_STORE = 4,
    parameter int MAX_CB    = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic                 abus_req,
    input logic                 abus_gnt,
    input logic                 addr_start,
    input logic                 aterm_retry,
    input logic                 dbus_req,
    input logic                 dterm,
    input logic                 done_valid,
    input logic [CW-1:0]        tot_cnt,
    input logic [2:0][CW-1:0]   kind_cnt,
    input logic                 a_tenure,
    input logic [AW-1:0]        hold_addr,
    input logic                 d_xfer
);
    assert_total_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tot_cnt <= CW'(MAX_TOTAL));

    assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tot_cnt == CW'(MAX_TOTAL)) |-> !req_ready);

    assert_kind_caps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_cnt[0] <= CW'(MAX_LOAD)) && (kind_cnt[1] <= CW'(MAX_STORE)) &&
        (kind_cnt[2] <= CW'(MAX_CB)));

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_start |=> !addr_start);

    assert_start_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_start |-> $past(abus_req && abus_gnt));

    assert_retry_reissue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_tenure && aterm_retry) |=> (abus_req && $stable(hold_addr)));

    assert_done_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(d_xfer && dterm));

    assert_no_dreq_in_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_req |-> !d_xfer);
endmodule

bind bus_trk_top bus_trk_checker #(
    .AW        (AW),
    .CW        (CW),
    .MAX_TOTAL (MAX_TOTAL),
    .MAX_LOAD  (MAX_LOAD),
    .MAX_STORE (MAX_STORE),
    .MAX_CB    (MAX_CB)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .abus_req    (abus_req),
    .abus_gnt    (abus_gnt),
    .addr_start  (addr_start),
    .aterm_retry (aterm_retry),
    .dbus_req    (dbus_req),
    .dterm       (dterm),
    .done_valid  (done_valid),
    .tot_cnt     (tot_cnt),
    .kind_cnt    (kind_cnt),
    .a_tenure    (a_tenure),
    .hold_addr   (hold_addr),
    .d_xfer      (d_xfer)
);

// File: tb/tb_bus_trk_top.sv
`timescale 1ns/1ps
module tb_bus_trk_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_tag = '0;
    logic        req_burst = 1'b0;
    logic [2:0]  req_size = '0;
    logic        req_wt = 1'b0;
    logic        req_ci = 1'b0;
    logic        abus_req;
    logic        abus_gnt = 1'b0;
    logic        addr_start;
    logic [31:0] a_addr;
    logic [1:0]  a_kind;
    logic [2:0]  a_size;
    logic        a_burst, a_wt, a_ci;
    logic        aterm_ack = 1'b0;
    logic        aterm_retry = 1'b0;
    logic        dbus_req;
    logic        dbus_gnt = 1'b0;
    logic        dterm = 1'b0;
    logic        done_valid;
    logic [3:0]  done_tag;

    always #2.5 clk = ~clk;

    bus_trk_top dut (.*);

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    int n_ats = 0;
    bit finished = 0;

    // Responder knobs, percent per cycle.
    int pa = 0, pk = 0, pr = 0, pd = 0, pt = 0;

    // Reference model state.
    typedef struct {
        logic [31:0] addr; logic [3:0] tag; logic [1:0] kind;
        logic burst; logic [2:0] size; logic wt; logic ci;
    } txn_t;
    int   ma = 0;
    txn_t mcur;
    txn_t mq[$];
    bit   mx = 0;
    int   mbeat = 0;
    int   mcnt[3] = '{0, 0, 0};
    int   mtot = 0;
    bit   mdone = 0;
    logic [3:0] mdtag = '0;

    function automatic int cap_of(int k);
        return (k == 0) ? 4 : (k == 1) ? 4 : 1;
    endfunction

    function automatic bit m_ready();
        if (ma != 0 || req_kind == 2'd3) return 0;
        return (mtot < 5) && (mcnt[req_kind] < cap_of(int'(req_kind)));
    endfunction

    task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, got, exp, $time);
        end
    endtask

    // Reference model step at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            ma = 0; mx = 0; mbeat = 0; mq.delete();
            mcnt = '{0, 0, 0}; mtot = 0; mdone = 0;
        end else begin
            bit acc;
            acc = req_valid && m_ready();
            mdone = 0;
            if (mx) begin
                if (dterm) begin
                    if (mbeat == (mq[0].burst ? 3 : 0)) begin
                        mdone = 1; mdtag = mq[0].tag;
                        mcnt[mq[0].kind]--; mtot--;
                        void'(mq.pop_front()); mx = 0;
                    end else mbeat++;
                end
            end else if (mq.size() > 0 && dbus_gnt) begin
                mx = 1; mbeat = 0;
            end
            case (ma)
                0: if (acc) begin
                    ma = 1;
                    mcur = '{req_addr, req_tag, req_kind, req_burst, req_size, req_wt, req_ci};
                    mcnt[req_kind]++; mtot++;
                end
                1: if (abus_gnt) ma = 2;
                default: begin
                    if (aterm_retry) ma = 1;
                    else if (aterm_ack) begin mq.push_back(mcur); ma = 0; end
                    else ma = 3;
                end
            endcase
        end
    end

    // Compare every output with the model between edges.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [40:0] exp_a;
            exp_a = (ma >= 2) ? {mcur.kind, mcur.size, mcur.burst, mcur.wt, mcur.ci, mcur.addr} : '0;
            if (addr_start) n_ats++;
            chk("R9/R10", "req_ready", req_ready, m_ready());
            chk("R2", "abus_req", abus_req, ma == 1);
            chk("R3", "addr_start", addr_start, ma == 2);
            chk("R3/R4", "addr+attrs", {a_kind, a_size, a_burst, a_wt, a_ci, a_addr}, exp_a);
            chk("R6", "dbus_req", dbus_req, !mx && mq.size() > 0);
            chk("R7", "done_valid", done_valid, mdone);
            if (mdone) chk("R8", "done_tag", done_tag, mdtag);
        end
    end

    // Random bus responders.
    always @(negedge clk) begin
        #1;
        abus_gnt    = int'($urandom_range(99)) < pa;
        aterm_ack   = int'($urandom_range(99)) < pk;
        aterm_retry = int'($urandom_range(99)) < pr;
        dbus_gnt    = int'($urandom_range(99)) < pd;
        dterm       = int'($urandom_range(99)) < pt;
    end

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
            summary();
        end
    end

    task automatic send(int k, logic [31:0] ad, logic [3:0] tg, bit bu);
        @(negedge clk); #1;
        req_kind = 2'(k); req_addr = ad; req_tag = tg; req_burst = bu;
        req_size = 3'($urandom_range(7)); req_wt = 1'($urandom_range(1));
        req_ci = 1'($urandom_range(1)); req_valid = 1'b1;
        #1;
        while (!req_ready) begin @(negedge clk); #2; end
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (ma != 0 || mq.size() > 0 || mx) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic probe(int k, bit exp, string req, string what);
        @(negedge clk); #1;
        req_kind = 2'(k);
        #1;
        chk(req, what, req_ready, exp);
    endtask

    initial begin
        int sent;
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "reset abus_req", abus_req, 0);
        chk("R1", "reset done_valid", done_valid, 0);
        #1 rst_n = 1'b1;
        @(negedge clk); #2;
        chk("R1", "post-reset req_ready", req_ready, 1);
        chk("R1", "post-reset dbus/ats", {dbus_req, addr_start}, 0);

        // R11: stray terminations with no traffic
        pa = 50; pk = 50; pr = 30; pd = 50; pt = 50;
        repeat (20) @(negedge clk);
        chk("R11", "stray terms: done/dbus/abus", {done_valid, dbus_req, abus_req}, 0);

        // Basic singles and bursts
        send(0, 32'h1000_0040, 4'h1, 0);
        send(1, 32'h2000_0080, 4'h2, 1);
        send(2, 32'h3000_00c0, 4'h3, 1);
        drain();

        // R4: retry-heavy address phases
        pr = 60; pk = 50;
        sent = n_ats;
        for (int i = 0; i < 5; i++) send(i % 3, 32'h4000_0000 + 32'(i * 32), 4'(i), i[0]);
        drain();
        chk("R4", "retries produced reissued starts", (n_ats - sent) > 5, 1);

        // Caps with data bus held off
        pa = 100; pk = 100; pr = 0; pd = 0; pt = 0;
        send(0, 32'h5000_0000, 4'h4, 0);
        repeat (4) @(negedge clk);
        probe(0, 1, "R5", "load ready while data pending");
        chk("R5", "dbus_req pending during new address", dbus_req, 1);
        for (int i = 1; i < 4; i++) send(0, 32'h5000_0000 + 32'(i * 32), 4'(4 + i), 0);
        repeat (4) @(negedge clk);
        probe(0, 0, "R10", "fifth load refused");
        probe(1, 1, "R10", "store eligible at load cap");
        send(1, 32'h6000_0000, 4'h9, 1);
        repeat (4) @(negedge clk);
        probe(2, 0, "R9", "copyback refused at total cap");
        probe(1, 0, "R9", "store refused at total cap");
        probe(3, 0, "R10", "code 3 never accepted");
        pd = 100; pt = 100;
        drain();

        // Copyback cap alone
        pd = 0; pt = 0;
        send(2, 32'h7000_0000, 4'ha, 1);
        repeat (4) @(negedge clk);
        probe(2, 0, "R10", "second copyback refused");
        probe(0, 1, "R10", "load eligible at copyback cap");
        pd = 60; pt = 60;
        drain();

        // Long mixed random stream
        pa = 60; pk = 50; pr = 15; pd = 60; pt = 60;
        for (int i = 0; i < 150; i++)
            send(int'($urandom_range(2)), $urandom, 4'(i), 1'($urandom_range(1)));
        drain();
        pa = 0; pk = 0; pr = 0; pd = 0; pt = 0;
        repeat (4) @(negedge clk);
        summary();
    end
endmodule